// File: doc/BRIEF.md
# I2C Target Engine with Restart-Aware Address Decoding

This block is the target (slave) side of a two-wire I2C bus. It samples the clock and data lines through synchronizers, recognises START, repeated START and STOP conditions, and shifts in the address byte that follows each START. When the seven address bits match the configured own address, the block acknowledges. The direction bit then selects one of two paths: it either receives bytes from the controller or sends bytes that the surrounding logic supplies.

The block never drives the clock. It pulls the data line low through an open-drain enable and releases it otherwise. Received bytes come out with a one-cycle strobe. Bytes to send are taken through a valid/ready pair. A busy output stays high for as long as the block is addressed.

START detection stays armed while a byte is being shifted in. A repeated START in the middle of a byte discards the partial byte and restarts address decoding. This allows a controller to write a register pointer and then switch to a read without sending a STOP in between.

Top module: `i2c_tgt_engine`

## Requirements
- R1: After reset, sda_oe, busy, rx_valid and tx_ready are all 0.
- R2: The first byte after a START is taken MSB first. If its bits [7:1] equal own_addr, the block drives sda_oe high (line low) during the ninth clock, and busy rises.
- R3: If the address does not match, the block gives no acknowledge, keeps busy low, and reports no byte (no rx_valid, no tx_ready) until the next START.
- R4: If the direction bit (bit 0) is 0, each following byte appears on rx_data with a one-cycle rx_valid pulse and is acknowledged on its ninth clock.
- R5: If the direction bit is 1, the block sends bytes MSB first. tx_ready pulses once as each byte is loaded. The byte on tx_data is taken when tx_valid is 1; otherwise 8'hFF is sent.
- R6: In the transmit path, a controller ACK (line low on the ninth clock) makes the block load and send the next byte. A NACK makes it release the line and load nothing more until the next START.
- R7: A repeated START (data falling while clock is high) during a byte discards the partial byte and decodes a new address and direction. Busy stays high if the new address matches and falls if it does not.
- R8: A STOP (data rising while clock is high) returns the block to idle, releases the line and clears busy.
- R9: sda_oe changes only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| own_addr | input | 7 | Configured target address |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| rx_data | output | 8 | Last byte received |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| tx_data | input | 8 | Next byte to send |
| tx_valid | input | 1 | tx_data holds a byte |
| tx_ready | output | 1 | One-cycle strobe, byte loaded |
| busy | output | 1 | Block is currently addressed |

## Verification
The bench attacks a repeated START placed four bits into a data byte. A design that leaves START disarmed during data would record a corrupt byte and never acknowledge the new read address. A non-matching address followed by a data byte checks that a decoder which falls through into receive mode is caught, because it would acknowledge the byte or strobe rx_valid. In the read path, a NACK followed by nine more clocks exposes a design that keeps loading bytes: the read-back value would differ from 8'hFF, or the tx_ready count would rise. An empty transmit source checks the 8'hFF filler. A watch on sda_oe flags any edge that lands while the clock is high, which on a real bus would look like a false START or STOP.

// File: rtl/i2c_tgt_pkg.sv
`timescale 1ns/1ps
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_ADDR_ACK, PH_RX, PH_RX_ACK, PH_TX, PH_TX_ACK, PH_HOLD
  } phase_e;

  // seven upper bits of the first byte carry the address
  function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                    input logic [ADDR_W-1:0] own);
    return b[BYTE_W-1:1] == own;
  endfunction

  // filler byte when the source is empty keeps the line released
  function automatic logic [BYTE_W-1:0] tx_pick(input logic v,
                                                input logic [BYTE_W-1:0] d);
    return v ? d : {BYTE_W{1'b1}};
  endfunction

  // open drain: a zero bit means pull low
  function automatic logic pull_for(input logic b);
    return ~b;
  endfunction
endpackage

// File: rtl/i2c_tgt_sync.sv
`timescale 1ns/1ps
module i2c_tgt_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] lvl,
  output logic [LINES-1:0] prev
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain   <= '1;
        prev[g] <= 1'b1;
      end else begin
        chain   <= {chain[STAGES-2:0], raw[g]};
        prev[g] <= chain[STAGES-1];
      end
    end
    assign lvl[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2c_tgt_events.sv
`timescale 1ns/1ps
module i2c_tgt_events (
  input  logic scl_now,
  input  logic scl_old,
  input  logic sda_now,
  input  logic sda_old,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_held_high;
  assign scl_held_high = scl_now & scl_old;
  assign scl_rise = scl_now & ~scl_old;
  assign scl_fall = ~scl_now & scl_old;
  assign start_ev = scl_held_high & sda_old & ~sda_now;
  assign stop_ev  = scl_held_high & ~sda_old & sda_now;
endmodule

// File: rtl/i2c_tgt_core.sv
`timescale 1ns/1ps
module i2c_tgt_core
  import i2c_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              sda_oe,
  output logic              busy,
  output phase_e            phase
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] rsh;
  logic [BYTE_W-1:0] tsh;
  logic              rd_dir;
  logic              ctl_ack;
  logic [BYTE_W-1:0] next_byte;

  assign next_byte = tx_pick(tx_valid, tx_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      rsh      <= '0;
      tsh      <= '1;
      rd_dir   <= 1'b0;
      ctl_ack  <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      tx_ready <= 1'b0;
      sda_oe   <= 1'b0;
      busy     <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      tx_ready <= 1'b0;
      if (stop_ev) begin
        phase  <= PH_IDLE;
        sda_oe <= 1'b0;
        busy   <= 1'b0;
        cnt    <= '0;
      end else if (start_ev) begin
        phase  <= PH_ADDR;
        sda_oe <= 1'b0;
        cnt    <= '0;
      end else begin
        unique case (phase)
          PH_ADDR: begin
            if (scl_rise && cnt != LAST) begin
              rsh <= {rsh[BYTE_W-2:0], sda_lvl};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST) begin
              if (addr_hit(rsh, own_addr)) begin
                sda_oe <= 1'b1;
                busy   <= 1'b1;
                rd_dir <= rsh[0];
                phase  <= PH_ADDR_ACK;
              end else begin
                busy  <= 1'b0;
                phase <= PH_HOLD;
              end
            end
          end
          PH_ADDR_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rd_dir) begin
                tsh      <= next_byte;
                tx_ready <= 1'b1;
                sda_oe   <= pull_for(next_byte[BYTE_W-1]);
                phase    <= PH_TX;
              end else begin
                sda_oe <= 1'b0;
                phase  <= PH_RX;
              end
            end
          end
          PH_RX: begin
            if (scl_rise && cnt != LAST) begin
              rsh <= {rsh[BYTE_W-2:0], sda_lvl};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST) begin
              rx_data  <= rsh;
              rx_valid <= 1'b1;
              sda_oe   <= 1'b1;
              phase    <= PH_RX_ACK;
            end
          end
          PH_RX_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              phase  <= PH_RX;
            end
          end
          PH_TX: begin
            if (scl_rise && cnt != LAST) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST) begin
              sda_oe <= 1'b0;
              phase  <= PH_TX_ACK;
            end else if (scl_fall && cnt != '0) begin
              tsh    <= {tsh[BYTE_W-2:0], 1'b1};
              sda_oe <= pull_for(tsh[BYTE_W-2]);
            end
          end
          PH_TX_ACK: begin
            if (scl_rise) begin
              ctl_ack <= ~sda_lvl;
            end else if (scl_fall) begin
              cnt <= '0;
              if (ctl_ack) begin
                tsh      <= next_byte;
                tx_ready <= 1'b1;
                sda_oe   <= pull_for(next_byte[BYTE_W-1]);
                phase    <= PH_TX;
              end else begin
                sda_oe <= 1'b0;
                phase  <= PH_HOLD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_tgt_engine.sv
`timescale 1ns/1ps
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              busy
);
  logic [1:0] lvl;
  logic [1:0] prev;
  logic       scl_lvl;
  logic       sda_lvl;
  logic       scl_rise;
  logic       scl_fall;
  logic       start_ev;
  logic       stop_ev;
  phase_e     phase;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw({sda_i, scl_i}), .lvl(lvl), .prev(prev)
  );

  assign scl_lvl = lvl[0];
  assign sda_lvl = lvl[1];

  i2c_tgt_events u_events (
    .scl_now(lvl[0]), .scl_old(prev[0]), .sda_now(lvl[1]), .sda_old(prev[1]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2c_tgt_core u_core (
    .clk(clk), .rst_n(rst_n), .own_addr(own_addr), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid),
    .sda_oe(sda_oe), .busy(busy), .phase(phase)
  );
endmodule

// File: rtl/i2c_tgt_checks.sv
`timescale 1ns/1ps
module i2c_tgt_checks
  import i2c_tgt_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   scl_lvl,
  input logic   start_ev,
  input logic   stop_ev,
  input logic   sda_oe,
  input logic   busy,
  input logic   rx_valid,
  input logic   tx_ready,
  input phase_e phase
);
  // R9
  oe_edge_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) && !$past(start_ev) && !$past(stop_ev) |-> !$past(scl_lvl));

  // R8
  stop_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !busy && !sda_oe && phase == PH_IDLE);

  // R7
  start_rearms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev && !stop_ev |=> phase == PH_ADDR && !sda_oe);

  // R4
  rx_only_when_addressed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> busy);

  // R5
  tx_only_when_addressed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> busy);

  // R3
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_HOLD && $past(phase) == PH_HOLD |-> !sda_oe && !rx_valid && !tx_ready);

  // R8
  conditions_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_ev, stop_ev}));
endmodule

bind i2c_tgt_engine i2c_tgt_checks u_checks (
  .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .start_ev(start_ev),
  .stop_ev(stop_ev), .sda_oe(sda_oe), .busy(busy), .rx_valid(rx_valid),
  .tx_ready(tx_ready), .phase(phase)
);

// File: tb/test_i2c_tgt_engine.sv
`timescale 1ns/1ps
module test_i2c_tgt_engine;
  localparam int Q = 5;
  localparam logic [6:0] OWN = 7'h52;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       sda_bus;
  logic       sda_oe;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic [7:0] tx_data;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic       busy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] rx_log [16];
  int         rx_cnt = 0;
  logic [7:0] tx_tbl [4];
  int         tx_ptr = 0;
  int         r9_bad = 0;
  logic       prev_oe = 1'b0;

  always #2.5 clk = ~clk;

  assign sda_bus = m_sda & ~sda_oe;
  assign tx_data = tx_tbl[tx_ptr[1:0]];

  i2c_tgt_engine i_i2c_tgt_engine (
    .clk(clk), .rst_n(rst_n), .own_addr(OWN), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .rx_data(rx_data), .rx_valid(rx_valid),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .busy(busy)
  );

  always @(negedge clk) begin
    if (rx_valid) begin
      rx_log[rx_cnt[3:0]] = rx_data;
      rx_cnt++;
    end
    if (tx_ready) tx_ptr++;
    if (rst_n && sda_oe != prev_oe && m_scl) r9_bad++;
    prev_oe = sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_start;
    m_sda = 1'b1; w(Q); m_scl = 1'b1; w(Q); m_sda = 1'b0; w(Q); m_scl = 1'b0; w(Q);
  endtask

  task automatic m_stop;
    m_sda = 1'b0; w(Q); m_scl = 1'b1; w(Q); m_sda = 1'b1; w(Q);
  endtask

  task automatic m_bit(input logic b, output logic r);
    m_sda = b; w(Q); m_scl = 1'b1; w(Q); r = sda_bus; w(Q); m_scl = 1'b0; w(Q);
  endtask

  task automatic m_put(input logic [7:0] d, output logic ack_low);
    logic r;
    for (int i = 7; i >= 0; i--) m_bit(d[i], r);
    m_bit(1'b1, r);
    ack_low = ~r;
  endtask

  task automatic m_get(input logic give_ack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      m_bit(1'b1, r);
      d[i] = r;
    end
    m_bit(~give_ack, r);
  endtask

  task automatic t_reset;
    chk(sda_oe == 0 && busy == 0 && rx_valid == 0 && tx_ready == 0, "R1 reset outputs",
        {sda_oe, busy, rx_valid, tx_ready}, 0);
  endtask

  task automatic t_write;
    logic a;
    int base = rx_cnt;
    m_start;
    m_put({OWN, 1'b0}, a);
    chk(a, "R2 address ack", a, 1);
    chk(busy, "R2 busy after match", busy, 1);
    m_put(8'hA5, a);
    chk(a, "R4 data ack 1", a, 1);
    m_put(8'h3C, a);
    chk(a, "R4 data ack 2", a, 1);
    chk(rx_cnt == base + 2, "R4 byte count", rx_cnt - base, 2);
    chk(rx_log[base[3:0]] == 8'hA5, "R4 byte 1", rx_log[base[3:0]], 8'hA5);
    chk(rx_log[4'(base + 1)] == 8'h3C, "R4 byte 2", rx_log[4'(base + 1)], 8'h3C);
    m_stop;
    w(Q);
    chk(!busy && !sda_oe, "R8 stop releases", {busy, sda_oe}, 0);
  endtask

  task automatic t_mismatch;
    logic a;
    int base = rx_cnt;
    int tb = tx_ptr;
    m_start;
    m_put({OWN ^ 7'h01, 1'b0}, a);
    chk(!a, "R3 no ack on mismatch", a, 0);
    chk(!busy, "R3 busy stays low", busy, 0);
    m_put(8'h00, a);
    chk(!a, "R3 data ignored no ack", a, 0);
    chk(rx_cnt == base && tx_ptr == tb, "R3 nothing reported", rx_cnt - base, 0);
    m_stop;
  endtask

  task automatic t_read;
    logic [7:0] d;
    int tb;
    tx_tbl[0] = 8'h96; tx_tbl[1] = 8'h4B; tx_tbl[2] = 8'h11; tx_tbl[3] = 8'h22;
    tx_ptr = 0;
    tx_valid = 1'b1;
    m_start;
    m_put({OWN, 1'b1}, d[0]);
    chk(d[0] && busy, "R2 read address ack", {d[0], busy}, 3);
    m_get(1'b1, d);
    chk(d == 8'h96, "R5 first byte", d, 8'h96);
    m_get(1'b0, d);
    chk(d == 8'h4B, "R6 byte after ack", d, 8'h4B);
    tb = tx_ptr;
    chk(tb == 2, "R5 tx_ready count", tb, 2);
    m_get(1'b0, d);
    chk(d == 8'hFF, "R6 line released after nack", d, 8'hFF);
    chk(tx_ptr == tb, "R6 no load after nack", tx_ptr, tb);
    m_stop;
    tx_valid = 1'b0;
  endtask

  task automatic t_empty;
    logic [7:0] d;
    logic a;
    m_start;
    m_put({OWN, 1'b1}, a);
    m_get(1'b0, d);
    chk(d == 8'hFF, "R5 empty source filler", d, 8'hFF);
    m_stop;
  endtask

  task automatic t_restart;
    logic a;
    logic r;
    logic [7:0] d;
    int base = rx_cnt;
    tx_tbl[0] = 8'hC3; tx_ptr = 0; tx_valid = 1'b1;
    m_start;
    m_put({OWN, 1'b0}, a);
    m_put(8'h07, a);
    for (int i = 0; i < 4; i++) m_bit(i[0], r);
    m_start;
    m_put({OWN, 1'b1}, a);
    chk(a && busy, "R7 readdress after restart", {a, busy}, 3);
    chk(rx_cnt == base + 1, "R7 partial byte discarded", rx_cnt - base, 1);
    m_get(1'b0, d);
    chk(d == 8'hC3, "R7 read after pointer write", d, 8'hC3);
    m_start;
    m_put({OWN, 1'b0}, a);
    for (int i = 0; i < 3; i++) m_bit(1'b1, r);
    m_start;
    m_put({OWN ^ 7'h40, 1'b0}, a);
    chk(!a && !busy, "R7 restart to other address drops busy", {a, busy}, 0);
    m_stop;
    tx_valid = 1'b0;
  endtask

  initial begin
    tx_tbl[0] = '0; tx_tbl[1] = '0; tx_tbl[2] = '0; tx_tbl[3] = '0;
    w(4);
    t_reset;
    rst_n = 1'b1;
    w(4);
    t_reset;
    t_write;
    t_mismatch;
    t_read;
    t_empty;
    t_restart;
    chk(r9_bad == 0, "R9 sda_oe edges with SCL high", r9_bad, 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule